// File: doc/BRIEF.md
# Processor Clock and Reset Generator

This block takes one fast oscillator clock and derives from it the clocks and the reset and ready levels that a processor and its peripherals consume. The processor clock runs at one third of the oscillator rate and is high for one oscillator period out of three. The peripheral clock runs at one fifth of the oscillator rate. The oscillator itself is also passed straight through to an output pin.

An active-low reset request arrives as an asynchronous digital level. The block turns it into a reset output that changes only on falling edges of the processor clock. After each request ends, the reset output stays high for a minimum number of processor clock periods, even when the request was a glitch shorter than one oscillator period. A ready request from slow memory or I/O is passed through a two-stage synchronizer so that the processor can insert wait states. A separate power-on reset input fixes the phase of both divided clocks.

Top module: `procClkRstGen`

## Requirements
- R1: After power-on reset is released, counting oscillator rising edges from 1, procClk is high exactly in the cycles that follow edges n with n mod 3 = 2. It therefore has a period of 3 oscillator cycles and is high for 1 of them.
- R2: After power-on reset is released, periClk is high exactly in the cycles that follow edges n with n mod 5 in {3,4}. It therefore has a period of 5 oscillator cycles and is high for 2 of them.
- R3: oscOut carries the oscillator clock unchanged.
- R4: While rstReqN is held low, rstOut goes high by the third oscillator edge and stays high for as long as the request lasts.
- R5: Once rstReqN returns high, rstOut is still high after the 13th oscillator edge that follows the release and is low after the 17th. This gives at least 4 full procClk periods of reset after every request.
- R6: A low pulse on rstReqN that is shorter than one oscillator period, at any procClk phase, still produces an rstOut pulse with the timing of R4 and R5.
- R7: rstOut changes only at oscillator edges where procClk goes from high to low.
- R8: While porN is low, procClk, periClk and readyOut are 0 and rstOut is 1. After porN is released with no request pending, rstOut is high after edge 14 and low after edge 15.
- R9: readyOut equals the value that readyReq had two oscillator rising edges earlier. Reset requests have no effect on this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Fast oscillator clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstReqN | input | 1 | Asynchronous reset request, active low |
| readyReq | input | 1 | Asynchronous ready request from slow devices |
| procClk | output | 1 | Processor clock, oscillator divided by 3, one-third duty |
| periClk | output | 1 | Peripheral clock, oscillator divided by 5 |
| oscOut | output | 1 | Oscillator pass-through |
| rstOut | output | 1 | Stretched reset aligned to procClk falling edges |
| readyOut | output | 1 | Synchronized ready |

## Verification
The reset stretcher and the ready synchronizer can both act in the same oscillator cycle. The bench provokes this by releasing a held reset request and raising readyReq at the same oscillator falling edge. readyOut must still change exactly two rising edges later, while rstOut keeps the R5 window. Short reset glitches are placed at each of the three procClk phases, so that the pending-request capture is exercised both when a falling edge is near and when none is.

// File: rtl/clkRstPkg.sv
package clkRstPkg;

  typedef struct packed {
    logic setRst;
    logic clrRst;
  } ctrlStrobes_t;

endpackage

// File: rtl/clkDivider.sv
module clkDivider #(
  parameter int DIV      = 3,
  parameter int HIGH_CNT = 1
) (
  input  logic oscClk,
  input  logic porN,
  output logic clkOut
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST   = CW'(DIV - 1);
  localparam logic [CW-1:0] HI_START = CW'(DIV - HIGH_CNT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cntNext;

  always_comb begin
    cntNext = (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // counter and output both start from zero so the phase after reset is fixed
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      cnt    <= '0;
      clkOut <= 1'b0;
    end else begin
      cnt    <= cntNext;
      clkOut <= (cntNext >= HI_START);
    end
  end

  // independent period monitor: cycles between successive rising edges
  logic       prevOut;
  logic       seenRise;
  logic [7:0] gap;

  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      prevOut  <= 1'b0;
      seenRise <= 1'b0;
      gap      <= '0;
    end else begin
      prevOut <= clkOut;
      if (clkOut && !prevOut) begin
        gap      <= 8'd1;
        seenRise <= 1'b1;
      end else if (gap != 8'hFF) begin
        gap <= gap + 8'd1;
      end
    end
  end

  // R1 R2
  period_chk: assert property (@(posedge oscClk) disable iff (!porN)
    (clkOut && !prevOut && seenRise) |-> (gap == 8'(DIV)));

endmodule

// File: rtl/crgDatapath.sv
module crgDatapath
  import clkRstPkg::*;
#(
  parameter int PROC_DIV    = 3,
  parameter int PROC_HIGH   = 1,
  parameter int PERI_DIV    = 5,
  parameter int PERI_HIGH   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         oscClk,
  input  logic         porN,
  input  logic         rstReqN,
  input  logic         readyReq,
  input  ctrlStrobes_t strobes,
  output logic         procClk,
  output logic         periClk,
  output logic         fallStb,
  output logic         reqHeld,
  output logic         rstOutQ,
  output logic         readyOut
);

  clkDivider #(.DIV(PROC_DIV), .HIGH_CNT(PROC_HIGH)) u_procDiv (
    .oscClk (oscClk),
    .porN   (porN),
    .clkOut (procClk)
  );

  clkDivider #(.DIV(PERI_DIV), .HIGH_CNT(PERI_HIGH)) u_periDiv (
    .oscClk (oscClk),
    .porN   (porN),
    .clkOut (periClk)
  );

  // procClk is registered: when it is high, the next oscillator edge lowers it
  assign fallStb = procClk;

  // reset request synchronizer: asynchronous capture, synchronous release
  logic                   asyncClr;
  logic [SYNC_STAGES-1:0] reqPipe;
  assign asyncClr = rstReqN & porN;

  always_ff @(posedge oscClk or negedge asyncClr) begin
    if (!asyncClr) reqPipe <= '1;
    else           reqPipe <= {reqPipe[SYNC_STAGES-2:0], 1'b0};
  end
  assign reqHeld = reqPipe[SYNC_STAGES-1];

  // ready synchronizer
  logic [SYNC_STAGES-1:0] rdyPipe;
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) rdyPipe <= '0;
    else       rdyPipe <= {rdyPipe[SYNC_STAGES-2:0], readyReq};
  end
  assign readyOut = rdyPipe[SYNC_STAGES-1];

  // reset output register, moved only by control strobes
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN)               rstOutQ <= 1'b1;
    else if (strobes.setRst) rstOutQ <= 1'b1;
    else if (strobes.clrRst) rstOutQ <= 1'b0;
  end

  // R7
  rst_on_fall_chk: assert property (@(posedge oscClk) disable iff (!porN)
    !$stable(rstOutQ) |-> $past(procClk));

  // R4
  held_req_chk: assert property (@(posedge oscClk) disable iff (!porN)
    (reqHeld && fallStb) |=> rstOutQ);

endmodule

// File: rtl/crgControl.sv
module crgControl
  import clkRstPkg::*;
#(
  parameter int MIN_RST_CLKS = 4
) (
  input  logic         oscClk,
  input  logic         porN,
  input  logic         fallStb,
  input  logic         reqHeld,
  input  logic         rstOutQ,
  output ctrlStrobes_t strobes
);
  localparam int CW = $clog2(MIN_RST_CLKS + 1);
  localparam logic [CW-1:0] LAST_QUIET = CW'(MIN_RST_CLKS - 1);

  logic          pend;
  logic [CW-1:0] quietCnt;
  logic          setCond;

  always_comb begin
    setCond        = fallStb && (reqHeld || pend);
    strobes.setRst = setCond;
    strobes.clrRst = fallStb && !setCond && rstOutQ && (quietCnt == LAST_QUIET);
  end

  // pend keeps a request seen between procClk falls; quietCnt counts request-free falls
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      pend     <= 1'b0;
      quietCnt <= '0;
    end else begin
      if (fallStb)      pend <= 1'b0;
      else if (reqHeld) pend <= 1'b1;

      if (setCond)                 quietCnt <= '0;
      else if (fallStb && rstOutQ) quietCnt <= strobes.clrRst ? '0 : quietCnt + 1'b1;
    end
  end

  // independent count of procClk falls seen while reset output is high
  logic [CW:0] hiFalls;
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) hiFalls <= '0;
    else if (fallStb) begin
      if (!rstOutQ)               hiFalls <= '0;
      else if (hiFalls != '1)     hiFalls <= hiFalls + 1'b1;
    end
  end

  // R5
  min_width_chk: assert property (@(posedge oscClk) disable iff (!porN)
    $fell(rstOutQ) |-> (hiFalls >= (CW+1)'(MIN_RST_CLKS)));

endmodule

// File: rtl/procClkRstGen.sv
module procClkRstGen
  import clkRstPkg::*;
#(
  parameter int PROC_DIV     = 3,
  parameter int PERI_DIV     = 5,
  parameter int MIN_RST_CLKS = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic oscClk,
  input  logic porN,
  input  logic rstReqN,
  input  logic readyReq,
  output logic procClk,
  output logic periClk,
  output logic oscOut,
  output logic rstOut,
  output logic readyOut
);
  localparam int PROC_HIGH = PROC_DIV / 3;
  localparam int PERI_HIGH = PERI_DIV / 2;

  ctrlStrobes_t strobes;
  logic         fallStb;
  logic         reqHeld;
  logic         rstOutQ;

  assign oscOut = oscClk;
  assign rstOut = rstOutQ;

  crgDatapath #(
    .PROC_DIV    (PROC_DIV),
    .PROC_HIGH   (PROC_HIGH),
    .PERI_DIV    (PERI_DIV),
    .PERI_HIGH   (PERI_HIGH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .oscClk   (oscClk),
    .porN     (porN),
    .rstReqN  (rstReqN),
    .readyReq (readyReq),
    .strobes  (strobes),
    .procClk  (procClk),
    .periClk  (periClk),
    .fallStb  (fallStb),
    .reqHeld  (reqHeld),
    .rstOutQ  (rstOutQ),
    .readyOut (readyOut)
  );

  crgControl #(
    .MIN_RST_CLKS (MIN_RST_CLKS)
  ) u_ctrl (
    .oscClk  (oscClk),
    .porN    (porN),
    .fallStb (fallStb),
    .reqHeld (reqHeld),
    .rstOutQ (rstOutQ),
    .strobes (strobes)
  );

endmodule

// File: tb/procClkRstGen_bench.sv
module procClkRstGen_bench;

  logic oscClk = 1'b0;
  always #4 oscClk = ~oscClk;

  logic porN = 1'b0;
  logic rstReqN = 1'b1;
  logic readyReq = 1'b0;
  logic procClk, periClk, oscOut, rstOut, readyOut;

  procClkRstGen u_procClkRstGen (
    .oscClk   (oscClk),
    .porN     (porN),
    .rstReqN  (rstReqN),
    .readyReq (readyReq),
    .procClk  (procClk),
    .periClk  (periClk),
    .oscOut   (oscOut),
    .rstOut   (rstOut),
    .readyOut (readyOut)
  );

  int total = 0;
  int bad   = 0;
  int k     = 0;

  always @(posedge oscClk) if (porN) k <= k + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at edge %0d: actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // clock monitor, R1 R2
  always @(negedge oscClk) begin
    if (porN && k > 0) begin
      check(procClk == ((k % 3) == 2), "R1", procClk, int'((k % 3) == 2));
      check(periClk == ((k % 5) >= 3), "R2", periClk, int'((k % 5) >= 3));
    end
  end

  // R7 monitor: every rstOut change must coincide with a procClk fall
  logic prevRst = 1'b1;
  logic prevProc = 1'b0;
  always @(negedge oscClk) begin
    if (porN && k > 1 && rstOut !== prevRst)
      check(prevProc && !procClk, "R7", int'({prevProc, procClk}), 2);
    prevRst  = rstOut;
    prevProc = procClk;
  end

  // ready scoreboard, R9
  typedef struct {
    int   due;
    logic val;
  } rdyItem_t;
  rdyItem_t rdyQ[$];
  rdyItem_t popped;

  always @(negedge oscClk) begin
    if (rdyQ.size() > 0 && rdyQ[0].due == k) begin
      popped = rdyQ.pop_front();
      check(readyOut == popped.val, "R9", readyOut, popped.val);
    end
  end

  task automatic setReady(input logic v);
    @(negedge oscClk);
    readyReq = v;
    rdyQ.push_back('{k + 2, v});
  endtask

  task automatic waitK(input int n);
    while (k < n) @(negedge oscClk);
  endtask

  task automatic shortPulse(input int phase);
    int base;
    for (int i = 0; i < phase; i++) @(negedge oscClk);
    @(negedge oscClk);
    #1 rstReqN = 1'b0;
    #2 rstReqN = 1'b1;
    base = k;
    waitK(base + 3);
    check(rstOut == 1'b1, "R6", rstOut, 1);
    waitK(base + 13);
    check(rstOut == 1'b1, "R6", rstOut, 1);
    waitK(base + 17);
    check(rstOut == 1'b0, "R6", rstOut, 0);
    waitK(base + 24);
  endtask

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    int base;
    // R8 power-on state
    repeat (3) @(negedge oscClk);
    check(procClk == 1'b0, "R8", procClk, 0);
    check(periClk == 1'b0, "R8", periClk, 0);
    check(rstOut == 1'b1, "R8", rstOut, 1);
    check(readyOut == 1'b0, "R8", readyOut, 0);
    @(negedge oscClk);
    porN = 1'b1;
    waitK(14);
    check(rstOut == 1'b1, "R8", rstOut, 1);
    waitK(15);
    check(rstOut == 1'b0, "R8", rstOut, 0);

    // R3 pass-through
    @(posedge oscClk);
    #1 check(oscOut == 1'b1, "R3", oscOut, 1);
    @(negedge oscClk);
    #1 check(oscOut == 1'b0, "R3", oscOut, 0);

    // R9 toggling patterns
    setReady(1'b1);
    setReady(1'b0);
    setReady(1'b1);
    repeat (4) @(negedge oscClk);
    setReady(1'b0);
    setReady(1'b0);
    setReady(1'b1);
    setReady(1'b0);
    repeat (4) @(negedge oscClk);

    // R4 held request
    @(negedge oscClk);
    rstReqN = 1'b0;
    base = k;
    waitK(base + 3);
    check(rstOut == 1'b1, "R4", rstOut, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge oscClk);
      check(rstOut == 1'b1, "R4", rstOut, 1);
    end

    // R5 release together with a ready change (R9 in the same cycle)
    @(negedge oscClk);
    rstReqN  = 1'b1;
    readyReq = 1'b1;
    rdyQ.push_back('{k + 2, 1'b1});
    base = k;
    waitK(base + 13);
    check(rstOut == 1'b1, "R5", rstOut, 1);
    waitK(base + 17);
    check(rstOut == 1'b0, "R5", rstOut, 0);
    setReady(1'b0);
    repeat (6) @(negedge oscClk);

    // R6 glitch at each procClk phase
    for (int ph = 0; ph < 3; ph++) shortPulse(ph);

    // glitch while ready toggles
    fork
      shortPulse(1);
      begin
        setReady(1'b1);
        setReady(1'b0);
        setReady(1'b1);
      end
    join
    repeat (10) @(negedge oscClk);
    finishRun();
  end

endmodule